// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This block works out which sprites of a fixed 32-entry sprite table are drawn on the coming scanline. Its work is split into two phases on every line. In the search phase, which runs during active display, it reads only the vertical coordinate of each sprite, one sprite per memory slot that the scheduler grants. It compares that coordinate with the next line number under a single sprite height shared by all sprites, and queues the indices of matching sprites in a five-entry queue. The first four queued sprites are displayable. The fifth records which sprite first exceeded the per-line limit.

In the fetch phase, which runs during horizontal blanking, the unit drains the queue. For each displayable sprite it reads that sprite's four attribute bytes and computes the address of the pattern row that the pixel logic will need on the next line. The unit issues one read request at a time. A read takes place in a cycle where both the request and the slot grant are high, and the byte returns on the data input one cycle later.

Top module: `spr_line_eval`

## Requirements
- R1: After `line_start`, the unit makes exactly 32 reads, one per sprite, in ascending index order. Sprite i is read at `ATTR_BASE + 4*i`, the byte at offset 0, which holds the vertical coordinate. A read happens only in a cycle where `mem_req` and `slot_grant` are both high.
- R2: Let y be a sprite's vertical coordinate and L be `line_num`. The sprite's row is (L + 1 - y) mod 256. The sprite is on the next line when that row is below 8 with `size16` = 0, or below 16 with `size16` = 1.
- R3: The matching sprites with the four lowest indices fill output slots 0 to 3 in ascending index order. `spr_valid` bit k is 1 exactly when slot k is filled, so the set bits always form a run starting at bit 0.
- R4: A fifth match sets `spr_overflow` and places that sprite's index on `spr_fifth`. Any later match on the same line changes no output. Without a fifth match, `spr_fifth` reads 0.
- R5: `spr_overflow` holds its value through the end of the line, including the fetch phase. `line_start` clears it, clears `spr_fifth` and empties the queue.
- R6: On `hblank_start`, `spr_valid` clears. For each queued displayable sprite n, in queue order, the unit then reads the four bytes at `ATTR_BASE + 4*n + 0..3`, so 4*min(matches,4) reads in total. The byte at offset 2 is the pattern name.
- R7: With `size16` = 0, the pattern address of a slot is `PAT_BASE + name*8 + row`, taken modulo 2^ADDR_W.
- R8: With `size16` = 1, the pattern address of a slot is `PAT_BASE + (name with its two low bits cleared)*8 + row`, taken modulo 2^ADDR_W.
- R9: Read data is taken from `mem_rdata` in the cycle after the granted request.
- R10: After reset, `mem_req`, `spr_valid` and `spr_overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Pulse that starts the search pass for the next line |
| hblank_start | input | 1 | Pulse that starts the attribute fetch phase |
| line_num | input | 8 | Current display line |
| size16 | input | 1 | Sprite height shared by all sprites: 0 gives 8 lines, 1 gives 16 lines |
| slot_grant | input | 1 | Memory slot granted to this unit in this cycle |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after a granted request |
| spr_pat_addr | output | SHOW_MAX*ADDR_W | Pattern row address per slot; slot k occupies bits [k*ADDR_W +: ADDR_W] |
| spr_valid | output | SHOW_MAX | Slot filled flags |
| spr_overflow | output | 1 | A fifth sprite matched on this line |
| spr_fifth | output | IDX_W | Index of the fifth matching sprite |

## Verification
The bound checker watches several properties on every cycle:
- every queue push follows a granted read by one cycle;
- every request address falls inside the attribute table;
- the queue never grows beyond five entries;
- the valid flags stay a contiguous run;
- the overflow flag stays set until the next line start, and line start clears it and the queue;
- hblank clears the slots.

Only the bench scenarios can show that the right sprites are chosen, which depends on the arithmetic of the match rule. The same holds for wrap-around of the row below line 0, and for the exact fetch order and pattern addresses under both heights. The bench sweeps many lines against dense and wrapping coordinate tables.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

  localparam int LINE_W = 8;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_SPR = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN  = 2'd1,
    PH_FETCH = 2'd2
  } spr_phase_e;

  // Row of a sprite on the line after cur_line, wrapping modulo 256.
  function automatic logic [LINE_W-1:0] spr_row(input logic [LINE_W-1:0] cur_line,
                                                 input logic [LINE_W-1:0] ycoord);
    spr_row = cur_line + LINE_W'(1) - ycoord;
  endfunction

  function automatic logic spr_hit(input logic [LINE_W-1:0] row, input logic tall);
    spr_hit = tall ? (row < LINE_W'(16)) : (row < LINE_W'(8));
  endfunction

  // Pattern row address, 16 bits wide; callers keep the low bits.
  function automatic logic [15:0] spr_pat(input logic [15:0] base,
                                          input logic [BYTE_W-1:0] name,
                                          input logic [LINE_W-1:0] row,
                                          input logic tall);
    logic [BYTE_W-1:0] nm;
    nm = tall ? {name[BYTE_W-1:2], 2'b00} : name;
    spr_pat = base + {5'd0, nm, 3'd0} + {8'd0, row};
  endfunction

endpackage

// File: rtl/spr_fifo.sv
module spr_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 5,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [PW-1:0] level
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && wp < FULL) wp <= wp + PW'(1);
      if (pop && rp < wp)    rp <= rp + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && push && wp < FULL) mem[wp] <= din;
  end

  assign head  = (rp < wp) ? mem[rp] : '0;
  assign level = wp - rp;
endmodule

// File: rtl/spr_y_test.sv
module spr_y_test
  import spr_eval_pkg::*;
(
  input  logic [LINE_W-1:0] cur_line,
  input  logic [LINE_W-1:0] ycoord,
  input  logic              tall,
  output logic              hit
);
  assign hit = spr_hit(spr_row(cur_line, ycoord), tall);
endmodule

// File: rtl/spr_pat_gen.sv
module spr_pat_gen
  import spr_eval_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int PAT_BASE = 14'h3800
) (
  input  logic [BYTE_W-1:0] name,
  input  logic [LINE_W-1:0] row,
  input  logic              tall,
  output logic [ADDR_W-1:0] addr
);
  logic [15:0] full;
  assign full = spr_pat(16'(PAT_BASE), name, row, tall);
  assign addr = full[ADDR_W-1:0];
endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
  import spr_eval_pkg::*;
#(
  parameter int NUM_SPR     = 32,
  parameter int SHOW_MAX    = 4,
  parameter int QUEUE_DEPTH = 5,
  parameter int ADDR_W      = 14,
  parameter int ATTR_BASE   = 14'h1B00,
  parameter int PAT_BASE    = 14'h3800,
  localparam int IDX_W  = $clog2(NUM_SPR),
  localparam int CNT_W  = $clog2(NUM_SPR + 1),
  localparam int LVL_W  = $clog2(QUEUE_DEPTH + 1),
  localparam int SLOT_W = $clog2(SHOW_MAX + 1),
  localparam int KW     = $clog2(SHOW_MAX)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_start,
  input  logic                       hblank_start,
  input  logic [7:0]                 line_num,
  input  logic                       size16,
  input  logic                       slot_grant,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic [7:0]                 mem_rdata,
  output logic [SHOW_MAX*ADDR_W-1:0] spr_pat_addr,
  output logic [SHOW_MAX-1:0]        spr_valid,
  output logic                       spr_overflow,
  output logic [IDX_W-1:0]           spr_fifth
);
  localparam logic [ADDR_W-1:0] ATTR_A    = ADDR_W'(ATTR_BASE);
  localparam logic [CNT_W-1:0]  CNT_END   = CNT_W'(NUM_SPR);
  localparam logic [LVL_W-1:0]  LVL_FULL  = LVL_W'(QUEUE_DEPTH);
  localparam logic [LVL_W-1:0]  LVL_SHOW  = LVL_W'(SHOW_MAX);
  localparam logic [SLOT_W-1:0] SLOT_SHOW = SLOT_W'(SHOW_MAX);

  spr_phase_e         phase_q;
  logic [CNT_W-1:0]   scan_idx_q;
  logic               pend_q, pend_scan_q;
  logic [IDX_W-1:0]   pend_idx_q;
  logic [1:0]         pend_byte_q;
  logic [KW-1:0]      pend_slot_q;
  logic               ovf_q;
  logic [IDX_W-1:0]   fifth_q;
  logic [SLOT_W-1:0]  fetch_n_q, fetch_k_q;
  logic [1:0]         byte_q;
  logic [7:0]         y_q, name_q;
  logic [ADDR_W-1:0]  pat_q [SHOW_MAX];
  logic [SHOW_MAX-1:0] valid_q;

  // Named internal events.
  logic               ev_access, ev_eval, ev_hit, ev_push, ev_pop, ev_fill, scan_hit;
  logic [IDX_W-1:0]   q_head;
  logic [LVL_W-1:0]   fifo_level;
  logic [ADDR_W-1:0]  pat_w;

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = '0;
    case (phase_q)
      PH_SCAN: begin
        mem_req  = scan_idx_q < CNT_END;
        mem_addr = ATTR_A + (ADDR_W'(scan_idx_q) << 2);
      end
      PH_FETCH: begin
        mem_req  = fetch_k_q < fetch_n_q;
        mem_addr = ATTR_A + (ADDR_W'(q_head) << 2) + ADDR_W'(byte_q);
      end
      default: ;
    endcase
  end

  assign ev_access = mem_req & slot_grant;
  assign ev_eval   = pend_q & pend_scan_q;
  assign ev_hit    = ev_eval & scan_hit;
  assign ev_push   = ev_hit & (fifo_level < LVL_FULL);
  assign ev_pop    = ev_access & (phase_q == PH_FETCH) & (byte_q == 2'd3);
  assign ev_fill   = pend_q & ~pend_scan_q & (pend_byte_q == 2'd3);

  spr_y_test u_y_test (
    .cur_line (line_num),
    .ycoord   (mem_rdata),
    .tall     (size16),
    .hit      (scan_hit)
  );

  spr_fifo #(.DEPTH(QUEUE_DEPTH), .W(IDX_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (line_start),
    .push  (ev_push),
    .din   (pend_idx_q),
    .pop   (ev_pop),
    .head  (q_head),
    .level (fifo_level)
  );

  spr_pat_gen #(.ADDR_W(ADDR_W), .PAT_BASE(PAT_BASE)) u_pat (
    .name (name_q),
    .row  (spr_row(line_num, y_q)),
    .tall (size16),
    .addr (pat_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      scan_idx_q  <= '0;
      pend_q      <= 1'b0;
      pend_scan_q <= 1'b0;
      pend_idx_q  <= '0;
      pend_byte_q <= '0;
      pend_slot_q <= '0;
      ovf_q       <= 1'b0;
      fifth_q     <= '0;
      fetch_n_q   <= '0;
      fetch_k_q   <= '0;
      byte_q      <= '0;
      y_q         <= '0;
      name_q      <= '0;
      valid_q     <= '0;
      for (int k = 0; k < SHOW_MAX; k++) pat_q[k] <= '0;
    end else begin
      pend_q <= ev_access & ~line_start;
      if (ev_access) begin
        pend_scan_q <= (phase_q == PH_SCAN);
        pend_idx_q  <= scan_idx_q[IDX_W-1:0];
        pend_byte_q <= byte_q;
        pend_slot_q <= fetch_k_q[KW-1:0];
      end
      if (line_start) begin
        phase_q    <= PH_SCAN;
        scan_idx_q <= '0;
        ovf_q      <= 1'b0;
        fifth_q    <= '0;
      end else if (hblank_start) begin
        phase_q   <= PH_FETCH;
        fetch_n_q <= (fifo_level > LVL_SHOW) ? SLOT_SHOW : SLOT_W'(fifo_level);
        fetch_k_q <= '0;
        byte_q    <= '0;
        valid_q   <= '0;
      end else begin
        case (phase_q)
          PH_SCAN:
            if (ev_access) scan_idx_q <= scan_idx_q + CNT_W'(1);
          PH_FETCH:
            if (ev_access) begin
              byte_q <= byte_q + 2'd1;
              if (byte_q == 2'd3) fetch_k_q <= fetch_k_q + SLOT_W'(1);
            end else if (fetch_k_q == fetch_n_q && !pend_q) begin
              phase_q <= PH_IDLE;
            end
          default: ;
        endcase
        if (ev_hit && fifo_level == LVL_SHOW) begin
          ovf_q   <= 1'b1;
          fifth_q <= pend_idx_q;
        end
        if (pend_q && !pend_scan_q) begin
          if (pend_byte_q == 2'd0) y_q    <= mem_rdata;
          if (pend_byte_q == 2'd2) name_q <= mem_rdata;
        end
        if (ev_fill) begin
          pat_q[pend_slot_q]   <= pat_w;
          valid_q[pend_slot_q] <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < SHOW_MAX; k++) begin : g_out
    assign spr_pat_addr[k*ADDR_W +: ADDR_W] = pat_q[k];
  end

  assign spr_valid    = valid_q;
  assign spr_overflow = ovf_q;
  assign spr_fifth    = fifth_q;
endmodule

// File: rtl/spr_line_eval_chk.sv
module spr_line_eval_chk #(
  parameter int NUM_SPR     = 32,
  parameter int SHOW_MAX    = 4,
  parameter int QUEUE_DEPTH = 5,
  parameter int ADDR_W      = 14,
  parameter int ATTR_BASE   = 14'h1B00,
  parameter int LVL_W       = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_start,
  input logic                hblank_start,
  input logic                mem_req,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [SHOW_MAX-1:0] spr_valid,
  input logic                spr_overflow,
  input logic                ev_push,
  input logic                ev_access,
  input logic [LVL_W-1:0]    fifo_level
);
  localparam logic [ADDR_W-1:0] ATTR_A = ADDR_W'(ATTR_BASE);
  localparam logic [ADDR_W-1:0] TBL_SZ = ADDR_W'(NUM_SPR * 4);
  localparam logic [LVL_W-1:0]  LVL_FULL = LVL_W'(QUEUE_DEPTH);

  a_r1_push_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> $past(ev_access));

  a_r6_addr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (ADDR_W'(mem_addr - ATTR_A) < TBL_SZ));

  a_r4_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_FULL);

  a_r3_valid_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((spr_valid + SHOW_MAX'(1)) & spr_valid) == '0);

  a_r5_overflow_held: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_overflow && !line_start) |=> spr_overflow);

  a_r5_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (!spr_overflow && fifo_level == '0));

  a_r6_hblank_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_start && !line_start) |=> spr_valid == '0);
endmodule

bind spr_line_eval spr_line_eval_chk #(
  .NUM_SPR(NUM_SPR), .SHOW_MAX(SHOW_MAX), .QUEUE_DEPTH(QUEUE_DEPTH),
  .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .hblank_start(hblank_start),
  .mem_req(mem_req), .mem_addr(mem_addr), .spr_valid(spr_valid),
  .spr_overflow(spr_overflow), .ev_push(ev_push), .ev_access(ev_access),
  .fifo_level(fifo_level)
);

// File: tb/spr_line_eval_bench.sv
module spr_line_eval_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int ATTR = 14'h1B00;
  localparam int PATB = 14'h3800;

  logic clk = 0, rst_n = 0, line_start = 0, hblank_start = 0, size16 = 0;
  logic [7:0] line_num = 0;
  logic slot_grant;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 0;
  logic [4*AW-1:0] spr_pat_addr;
  logic [3:0] spr_valid;
  logic spr_overflow;
  logic [4:0] spr_fifth;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] attr_mem [128];
  logic [1:0] gcnt = 0;
  bit in_fetch = 0;
  int scnt = 0, serr = 0, fcnt = 0;
  int faddr [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign slot_grant = (gcnt == 2'd3);

  spr_line_eval u_spr_line_eval (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .hblank_start(hblank_start),
    .line_num(line_num), .size16(size16), .slot_grant(slot_grant),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .spr_pat_addr(spr_pat_addr), .spr_valid(spr_valid),
    .spr_overflow(spr_overflow), .spr_fifth(spr_fifth)
  );

  // Memory model and access log (R9: data appears the cycle after the grant).
  always @(posedge clk) begin
    gcnt <= gcnt + 2'd1;
    if (mem_req && slot_grant) begin
      int off;
      off = int'(mem_addr) - ATTR;
      mem_rdata <= (off >= 0 && off < 128) ? attr_mem[off] : 8'hEE;
      if (in_fetch) begin
        if (fcnt < 16) faddr[fcnt] = int'(mem_addr);
        fcnt++;
      end else begin
        if (int'(mem_addr) != ATTR + 4*scnt) serr++;
        scnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_line(input int L, input bit tall);
    int list [5];
    int rows [5];
    int n, nq, h;
    @(negedge clk);
    line_num = 8'(L); size16 = tall; in_fetch = 0; scnt = 0; serr = 0;
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    check(spr_overflow == 0, "R5 overflow cleared by line_start", int'(spr_overflow), 0);
    repeat (136) @(negedge clk);
    check(scnt == 32, "R1 scan read count", scnt, 32);
    check(serr == 0, "R1 scan address order", serr, 0);
    in_fetch = 1; fcnt = 0;
    hblank_start = 1;
    @(negedge clk);
    hblank_start = 0;
    repeat (72) @(negedge clk);
    // Expected result from the match rule (R2).
    n = 0; h = tall ? 16 : 8;
    for (int i = 0; i < 32; i++) begin
      int row;
      row = (L + 1 - int'(attr_mem[4*i])) & 255;
      if (row < h) begin
        if (n < 5) begin list[n] = i; rows[n] = row; end
        n++;
      end
    end
    nq = (n > 4) ? 4 : n;
    check(spr_overflow == (n >= 5), "R4 R5 overflow flag", int'(spr_overflow), int'(n >= 5));
    check(int'(spr_fifth) == ((n >= 5) ? list[4] : 0), "R4 fifth index",
          int'(spr_fifth), (n >= 5) ? list[4] : 0);
    check(int'(spr_valid) == ((1 << nq) - 1), "R2 R3 valid mask", int'(spr_valid), (1 << nq) - 1);
    check(fcnt == 4*nq, "R6 fetch read count", fcnt, 4*nq);
    for (int k = 0; k < nq; k++) begin
      int nm, exp;
      for (int b = 0; b < 4; b++)
        check(faddr[4*k+b] == ATTR + 4*list[k] + b, "R6 fetch address",
              faddr[4*k+b], ATTR + 4*list[k] + b);
      nm = int'(attr_mem[4*list[k] + 2]);
      if (tall) nm = nm & 8'hFC;
      exp = (PATB + nm*8 + rows[k]) & 16'h3FFF;
      check(int'(spr_pat_addr[k*AW +: AW]) == exp,
            tall ? "R8 R9 pattern address 16-line" : "R7 R9 pattern address 8-line",
            int'(spr_pat_addr[k*AW +: AW]), exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mem_req == 0, "R10 reset request", int'(mem_req), 0);
    check(spr_valid == 0, "R10 reset valid", int'(spr_valid), 0);
    check(spr_overflow == 0, "R10 reset overflow", int'(spr_overflow), 0);
    rst_n = 1;
    // Table A: spread coordinates.
    for (int i = 0; i < 32; i++) begin
      attr_mem[4*i]   = 8'((i*5) & 255);
      attr_mem[4*i+1] = 8'(i*9);
      attr_mem[4*i+2] = 8'((i*37 + 11) & 255);
      attr_mem[4*i+3] = 8'(i);
    end
    for (int L = 0; L < 80; L++) run_line(L, 0);
    for (int L = 0; L < 80; L++) run_line(L, 1);
    // Table B: clustered near the bottom so rows wrap and overflow occurs.
    for (int i = 0; i < 32; i++) begin
      attr_mem[4*i]   = 8'(248 + ((i*3) % 16));
      attr_mem[4*i+2] = 8'((i*53 + 200) & 255);
    end
    for (int L = 240; L < 272; L++) run_line(L & 255, 0);
    for (int L = 240; L < 272; L++) run_line(L & 255, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule